// File: doc/BRIEF.md
# Prescaled Counter PWM Generator

This block produces one pulse-width-modulated output from a single free-running 8-bit counter. The counter advances only on a slow tick strobe, nominally 32 kHz, supplied by the surrounding chip. The counter has no period-compare register. A 2-bit prescaler chooses which counter bit ends the period, so the period is 128, 64, 32 or 16 ticks. At the nominal tick rate these periods give 250 Hz, 500 Hz, 1 kHz and 2 kHz. A shorter period leaves fewer counter bits for the duty comparison.

Software reaches the block through a small byte-wide register port with separate synchronous write and read strobes. The control byte holds a run bit and the prescaler. The duty byte holds a 7-bit threshold. A change to either register takes effect on the next clock. No update waits for a period boundary, and a prescaler change leaves the counter where it is.

Top module: `prescaled_pwm`

## Requirements
- R1: After reset both registers read as zero, the counter is zero and `pwm_o` is low.
- R2: A write to offset 0 stores bit 7 as the run bit and bits 1:0 as the prescaler. A write to offset 1 stores bits 6:0 as the duty value. A read pulse returns the stored fields on `rd_data_o` one clock later, and every unused bit reads as zero.
- R3: Writes to offsets 2 and 3 change nothing, and reads from those offsets return zero.
- R4: While the run bit is set, the counter advances by one on each clock that has `tick_i` high and holds on every other clock. While the run bit is clear, the counter is held at zero and `pwm_o` is low.
- R5: With prescaler p, the counter returns to zero on the tick whose incremented value has bit 7-p set. The output period is therefore 2^(7-p) ticks.
- R6: While running, `pwm_o` is high exactly when the low 7-p counter bits are strictly less than the duty value. A duty value of zero keeps `pwm_o` low.
- R7: A duty value equal to or above the period keeps `pwm_o` high for the whole period. With prescaler 0 the largest duty value, 127, still leaves one low tick in each period.
- R8: Changing the prescaler does not clear the counter. The next comparison uses the old counter value masked to the new width.
- R9: A new duty value drives `pwm_o` on the clock that follows the write, in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Counter advance strobe |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write offset |
| wr_data_i | input | 8 | Write data |
| rd_en_i | input | 1 | Register read strobe |
| rd_addr_i | input | ADDR_W | Read offset |
| rd_data_o | output | 8 | Read data, valid one clock after the strobe |
| pwm_o | output | 1 | PWM output |

## Verification
The bench sweeps every prescaler against duty values of 0, 1, half the period, the period minus one, the period itself and 127. It checks the output on every tick for two full periods. An off-by-one wrap bit would show as a period that is wrong by a factor of two, and a compare written as less-or-equal would leave duty 0 with a high tick. A design that clears the counter when the prescaler changes is caught by a duty of 3 set against a retained count of 20 masked to 4. Writes to the unmapped offsets, a mid-period duty change and a disable during a run each have a targeted check.

// File: rtl/prescaled_pwm.sv
module prescaled_pwm #(
  parameter int CNT_W  = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o,
  output logic              pwm_o
);
  localparam int DUTY_W = CNT_W - 1;
  localparam int SEL_W  = $clog2(CNT_W);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFS_DUTY = ADDR_W'(1);

  logic              run_q;
  logic [1:0]        pre_q;
  logic [DUTY_W-1:0] duty_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [7:0]        rd_q;

  logic [SEL_W-1:0]  wrap_sel;
  logic [CNT_W-1:0]  cnt_inc, span, cnt_low;
  logic              ctrl_wr;

  assign wrap_sel = SEL_W'(CNT_W - 1) - SEL_W'(pre_q);
  assign span     = CNT_W'(1) << wrap_sel;
  assign cnt_inc  = cnt_q + CNT_W'(1);
  assign cnt_low  = cnt_q & (span - CNT_W'(1));
  assign ctrl_wr  = wr_en_i && (wr_addr_i == OFS_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      pre_q  <= 2'd0;
      duty_q <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == OFS_CTRL) begin
        run_q <= wr_data_i[7];
        pre_q <= wr_data_i[1:0];
      end else if (wr_addr_i == OFS_DUTY) begin
        duty_q <= wr_data_i[DUTY_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run_q)     cnt_q <= '0;
    else if (tick_i)     cnt_q <= cnt_inc[wrap_sel] ? '0 : cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= 8'h00;
    else if (rd_en_i) begin
      if (rd_addr_i == OFS_CTRL)      rd_q <= {run_q, 5'b0, pre_q};
      else if (rd_addr_i == OFS_DUTY) rd_q <= 8'(duty_q);
      else                            rd_q <= 8'h00;
    end
  end

  assign rd_data_o = rd_q;
  assign pwm_o     = run_q && (CNT_W'(duty_q) > cnt_low);

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |=> cnt_q == '0); // R4
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q) |-> !pwm_o); // R4
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && !tick_i && !ctrl_wr) |=> $stable(cnt_q)); // R4
  AST_STEP_OR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_i && !ctrl_wr) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0)); // R5
  AST_ZERO_DUTY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_q == '0) |-> !pwm_o); // R6
  AST_FULL_DUTY_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && CNT_W'(duty_q) >= span) |-> pwm_o); // R7
  AST_PRE0_LAST_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q == 2'd0 && cnt_q[DUTY_W-1:0] == '1) |-> !pwm_o); // R7
  AST_UNMAPPED_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en_i && rd_addr_i > OFS_DUTY) |=> rd_data_o == 8'h00); // R3
endmodule

// File: tb/prescaled_pwm_tb.sv
module prescaled_pwm_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = 2'd0;
  logic [7:0] wr_data_i = 8'h00;
  logic       rd_en_i = 1'b0;
  logic [1:0] rd_addr_i = 2'd0;
  logic [7:0] rd_data_o;
  logic       pwm_o;

  int vecs = 0, errs = 0;
  bit done = 0;
  int mcnt = 0, mpre = 0, mduty = 0;
  bit men = 0;

  always #10 clk = ~clk;

  prescaled_pwm dut_i (.*);

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int per_of(int p);
    return 128 >> p;
  endfunction

  function automatic int exp_pwm();
    if (!men) return 0;
    return ((mcnt & (per_of(mpre) - 1)) < mduty) ? 1 : 0;
  endfunction

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = 2'(a); wr_data_i = 8'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
    if (a == 0) begin
      men = d[7]; mpre = d & 3;
      if (!men) mcnt = 0;
    end else if (a == 1) mduty = d & 127;
  endtask

  task automatic rd(int a, int exp, string req);
    @(negedge clk);
    rd_en_i = 1'b1; rd_addr_i = 2'(a);
    @(negedge clk);
    rd_en_i = 1'b0;
    chk(req, int'(rd_data_o), exp);
  endtask

  task automatic tk(string req);
    int n;
    @(negedge clk);
    tick_i = 1'b1;
    @(negedge clk);
    tick_i = 1'b0;
    if (men) begin
      n = mcnt + 1;
      mcnt = ((n >> (7 - mpre)) & 1) ? 0 : n;
    end
    chk(req, int'(pwm_o), exp_pwm());
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm", int'(pwm_o), 0);
    rd(0, 0, "R1 ctrl");
    rd(1, 0, "R1 duty");

    wr(0, 8'hFF); rd(0, 8'h83, "R2 ctrl fields");
    wr(1, 8'hFF); rd(1, 8'h7F, "R2 duty fields");
    wr(0, 8'h00); wr(1, 0);

    for (int p = 0; p < 4; p++) begin
      int per = per_of(p);
      int dl[6];
      dl = '{0, 1, per / 2, per - 1, (per > 127) ? 127 : per, 127};
      wr(0, 8'h00);
      wr(0, 8'h80 | p);
      for (int k = 0; k < 6; k++) begin
        wr(1, dl[k]);
        chk("R6 R7 after duty write", int'(pwm_o), exp_pwm());
        for (int t = 0; t < 2 * per; t++)
          tk((dl[k] >= per) ? "R5 R7 full" : "R5 R6 compare");
      end
    end

    wr(0, 8'h00); wr(1, 127);
    wr(0, 8'h80);
    for (int t = 0; t < 127; t++) tk("R7 pre0 high");
    chk("R7 pre0 cnt127 low", int'(pwm_o), 0);
    tk("R5 pre0 wrap");

    wr(0, 8'h00); wr(1, 3); wr(0, 8'h80);
    for (int t = 0; t < 20; t++) tk("R8 run up");
    wr(0, 8'h83);
    chk("R8 counter kept", int'(pwm_o), 0);
    tk("R8 after wrap");
    chk("R8 wrapped high", int'(pwm_o), 1);

    wr(0, 8'h00); wr(0, 8'h82); wr(1, 10);
    for (int t = 0; t < 12; t++) tk("R9 run");
    chk("R9 before", int'(pwm_o), 0);
    wr(1, 20);
    chk("R9 immediate", int'(pwm_o), 1);

    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      chk("R4 no tick hold", int'(pwm_o), 1);
    end
    wr(0, 8'h02);
    chk("R4 disabled low", int'(pwm_o), 0);
    for (int t = 0; t < 5; t++) tk("R4 disabled ticks");
    wr(0, 8'h82);
    chk("R4 restart from zero", int'(pwm_o), 1);
    for (int t = 0; t < 20; t++) tk("R4 run after restart");

    wr(2, 8'hFF); wr(3, 8'h00);
    rd(0, 8'h82, "R3 ctrl untouched");
    rd(1, 20, "R3 duty untouched");
    rd(2, 0, "R3 read 2");
    rd(3, 0, "R3 read 3");
    tk("R3 pwm unchanged");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule